// File: doc/BRIEF.md
# Host/Coprocessor Mailbox Pair

This block holds two one-entry message mailboxes between a host CPU and a coprocessor. One carries mail from the host to the coprocessor and the other carries mail back. The host reaches both through a 16-bit register bus that uses byte addresses. Each 32-bit mailbox is seen as two halfwords. Big-endian order places the high halfword at the lower address. Bit 15 of each high halfword is a message-valid flag, so a message carries a 31-bit payload.

To send mail, the host writes the low halfword and then the high halfword with the flag set. The coprocessor sees the message only after the high-halfword write. It consumes the message with a one-cycle take strobe, which clears the flag. The host can poll the flag to learn whether its mail is still pending.

Mail in the other direction works as follows. The coprocessor posts a payload with a one-cycle strobe. The flag sets and a single-cycle interrupt pulse is produced. The host reads the message, and its read of the low halfword marks the mail as consumed. If the coprocessor posts again while mail is still pending, the new message replaces the old one and a sticky overrun indicator is raised.

Top module: `mbox_top`

## Requirements
- R1: After reset both flags are 0, `out_irq` and `out_overrun` are 0, and every register reads 0.
- R2: The address map is fixed: inbound high at byte offset 0x0, inbound low at 0x2, outbound high at 0x4, outbound low at 0x6. In each high halfword, bit 15 is the flag and bits 14:0 are payload bits 30:16. Each low halfword holds payload bits 15:0. Any other address, including an odd one, reads 0 and ignores writes.
- R3: A write to 0x2 only stages the low halfword. A write to 0x0 publishes {bits 14:0, staged low} to `cp_in_data` and loads the flag from bit 15. The coprocessor-side outputs change only in the cycle after that write.
- R4: The host reads back the staged inbound low halfword at 0x2 and the published inbound high halfword, with its flag, at 0x0.
- R5: When `cp_in_take` is high while the inbound flag is set, the flag clears in the next cycle and the payload is kept. A take with no pending mail has no effect. A high-halfword write in the same cycle as a take wins over the take.
- R6: The outbound halfwords are read-only. Writes to 0x4 and 0x6 change nothing.
- R7: `cp_out_post` loads `cp_out_data` and sets the outbound flag in the next cycle. The message is then readable at 0x4 and 0x6.
- R8: A host read of 0x6 clears the outbound flag in the next cycle. A read of 0x4 leaves the flag set.
- R9: `out_irq` is high for exactly one cycle: the first cycle in which the outbound flag reads 1 after having been 0.
- R10: A post that finds the flag set replaces the message and sets `out_overrun`, which stays set until reset. This applies only when the flag is not being cleared in the same cycle. A post in the same cycle as a read of 0x6 replaces the message and keeps the flag set, with no new interrupt and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Read data, same cycle as the strobe |
| cp_in_valid | output | 1 | Inbound flag |
| cp_in_data | output | 2*HALF_W-1 | Inbound payload |
| cp_in_take | input | 1 | Coprocessor consumes inbound mail |
| cp_out_post | input | 1 | Coprocessor posts outbound mail |
| cp_out_data | input | 2*HALF_W-1 | Outbound payload to post |
| cp_out_full | output | 1 | Outbound flag |
| out_irq | output | 1 | One-cycle pulse on new outbound mail |
| out_overrun | output | 1 | Sticky: outbound mail overwritten while pending |

## Verification
Read data is combinational, so its value is due in the same cycle as the read strobe. Every other result lands one clock edge after its stimulus. These results are flag set and clear, payload publication, the interrupt pulse and overrun. The bench drives each strobe on a falling edge and checks read data a few nanoseconds later, before the rising edge that applies any side effect. It checks registered outputs at the following falling edge, one edge after the stimulus. It checks the interrupt in that cycle and again one cycle later, to confirm that it lasts a single cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Byte offsets of the four halfwords (big-endian: high half first).
    localparam int OFS_IN_HI  = 0;
    localparam int OFS_IN_LO  = 2;
    localparam int OFS_OUT_HI = 4;
    localparam int OFS_OUT_LO = 6;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_IN_HI,
        RSEL_IN_LO,
        RSEL_OUT_HI,
        RSEL_OUT_LO
    } rsel_e;

    typedef struct packed {
        logic  wr_in_hi;
        logic  wr_in_lo;
        logic  rd_out_lo;
        rsel_e rsel;
    } strobe_t;

endpackage

// File: rtl/mbox_regdec.sv
module mbox_regdec
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output strobe_t           stb
);

    always_comb begin
        stb = '0;
        stb.rsel = RSEL_NONE;
        if (sel) begin
            if (addr == ADDR_W'(OFS_IN_HI)) begin
                stb.wr_in_hi = wr;
                stb.rsel     = RSEL_IN_HI;
            end else if (addr == ADDR_W'(OFS_IN_LO)) begin
                stb.wr_in_lo = wr;
                stb.rsel     = RSEL_IN_LO;
            end else if (addr == ADDR_W'(OFS_OUT_HI)) begin
                stb.rsel     = RSEL_OUT_HI;
            end else if (addr == ADDR_W'(OFS_OUT_LO)) begin
                stb.rd_out_lo = !wr;
                stb.rsel      = RSEL_OUT_LO;
            end
        end
    end

endmodule

// File: rtl/mbox_inbound.sv
module mbox_inbound #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wdata,
    input  logic              take,
    output logic              valid,
    output logic [2*HALF_W-2:0] msg,
    output logic [HALF_W-1:0] rd_hi,
    output logic [HALF_W-1:0] rd_lo
);

    localparam int PAY_W = 2*HALF_W - 1;

    typedef struct packed {
        logic              flag;
        logic [PAY_W-1:0]  msg;
        logic [HALF_W-1:0] stage_lo;
    } in_state_t;

    in_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo)
            st_d.stage_lo = wdata;
        if (take && st_q.flag)
            st_d.flag = 1'b0;
        if (wr_hi) begin
            st_d.flag = wdata[HALF_W-1];
            st_d.msg  = {wdata[HALF_W-2:0], st_q.stage_lo};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.flag;
    assign msg   = st_q.msg;
    assign rd_hi = {st_q.flag, st_q.msg[PAY_W-1:HALF_W]};
    assign rd_lo = st_q.stage_lo;

    // R5: a take of pending mail clears the flag unless a new message lands
    p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && valid && !wr_hi) |=> !valid);
    // R3: the flag follows bit 15 of a high-halfword write
    p_publish_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (valid == $past(wdata[HALF_W-1])));
    // R3: the payload seen by the coprocessor moves only on a high write
    p_payload_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(msg));
    // R3: the flag never sets without a high write
    p_no_self_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !wr_hi) |=> !valid);

endmodule

// File: rtl/mbox_outbound.sv
module mbox_outbound #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                post,
    input  logic [2*HALF_W-2:0] post_data,
    input  logic                rd_lo,
    output logic                full,
    output logic [2*HALF_W-2:0] msg,
    output logic                irq,
    output logic                overrun
);

    localparam int PAY_W = 2*HALF_W - 1;

    typedef struct packed {
        logic             flag;
        logic [PAY_W-1:0] msg;
        logic             irq;
        logic             ovr;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_lo)
            st_d.flag = 1'b0;
        if (post) begin
            st_d.msg  = post_data;
            st_d.flag = 1'b1;
            if (st_q.flag && !rd_lo)
                st_d.ovr = 1'b1;
        end
        st_d.irq = st_d.flag && !st_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full    = st_q.flag;
    assign msg     = st_q.msg;
    assign irq     = st_q.irq;
    assign overrun = st_q.ovr;

    // R7: a post always leaves mail pending
    p_post_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> full);
    // R8: reading the low half without a new post consumes the mail
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !post) |=> !full);
    // R9: the interrupt is a single-cycle pulse
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R9: the interrupt marks a 0-to-1 change of the flag
    p_irq_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (full && !$past(full)));
    // R10: overrun is sticky
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [HALF_W-1:0]   bus_wdata,
    output logic [HALF_W-1:0]   bus_rdata,
    output logic                cp_in_valid,
    output logic [2*HALF_W-2:0] cp_in_data,
    input  logic                cp_in_take,
    input  logic                cp_out_post,
    input  logic [2*HALF_W-2:0] cp_out_data,
    output logic                cp_out_full,
    output logic                out_irq,
    output logic                out_overrun
);

    localparam int PAY_W = 2*HALF_W - 1;

    strobe_t            stb;
    logic [HALF_W-1:0]  in_rd_hi, in_rd_lo;
    logic [PAY_W-1:0]   out_msg;

    mbox_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .stb  (stb)
    );

    mbox_inbound #(.HALF_W(HALF_W)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (stb.wr_in_hi),
        .wr_lo (stb.wr_in_lo),
        .wdata (bus_wdata),
        .take  (cp_in_take),
        .valid (cp_in_valid),
        .msg   (cp_in_data),
        .rd_hi (in_rd_hi),
        .rd_lo (in_rd_lo)
    );

    mbox_outbound #(.HALF_W(HALF_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .post      (cp_out_post),
        .post_data (cp_out_data),
        .rd_lo     (stb.rd_out_lo),
        .full      (cp_out_full),
        .msg       (out_msg),
        .irq       (out_irq),
        .overrun   (out_overrun)
    );

    always_comb begin
        unique case (stb.rsel)
            RSEL_IN_HI:  bus_rdata = in_rd_hi;
            RSEL_IN_LO:  bus_rdata = in_rd_lo;
            RSEL_OUT_HI: bus_rdata = {cp_out_full, out_msg[PAY_W-1:HALF_W]};
            RSEL_OUT_LO: bus_rdata = out_msg[HALF_W-1:0];
            default:     bus_rdata = '0;
        endcase
    end

    // R2: nothing is driven onto the read bus without an access
    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));

endmodule

// File: tb/test_mbox_top.sv
module test_mbox_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, take = 1'b0, post = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [30:0] pdata = '0;
    logic [15:0] rdata;
    logic        in_valid, out_full, irq, ovr;
    logic [30:0] in_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mbox_top i_mbox_top (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata),
        .cp_in_valid(in_valid), .cp_in_data(in_data), .cp_in_take(take),
        .cp_out_post(post), .cp_out_data(pdata), .cp_out_full(out_full),
        .out_irq(irq), .out_overrun(ovr)
    );

    // op: 0 read, 1 write, 2 post, 3 take
    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [30:0] data;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 3'h2, 31'h5678,     16'h0000}, // R3 stage low
        '{2'd0, 3'h0, 31'h0,        16'h0000}, // R3 not published
        '{2'd0, 3'h2, 31'h0,        16'h5678}, // R4 staged low readback
        '{2'd1, 3'h0, 31'h9234,     16'h0000}, // R3 publish with flag
        '{2'd0, 3'h0, 31'h0,        16'h9234}, // R4 high readback
        '{2'd3, 3'h0, 31'h0,        16'h0000}, // R5 take
        '{2'd0, 3'h0, 31'h0,        16'h1234}, // R5 flag cleared, payload kept
        '{2'd3, 3'h0, 31'h0,        16'h0000}, // R5 take with nothing pending
        '{2'd0, 3'h0, 31'h0,        16'h1234}, // R5 no effect
        '{2'd2, 3'h0, 31'h2AAA5555, 16'h0000}, // R7 post
        '{2'd0, 3'h4, 31'h0,        16'hAAAA}, // R7 flag + high payload
        '{2'd0, 3'h6, 31'h0,        16'h5555}, // R7 low payload (clears)
        '{2'd0, 3'h4, 31'h0,        16'h2AAA}, // R8 flag cleared by low read
        '{2'd1, 3'h4, 31'hFFFF,     16'h0000}, // R6 write ignored
        '{2'd1, 3'h6, 31'h1234,     16'h0000}, // R6 write ignored
        '{2'd0, 3'h4, 31'h0,        16'h2AAA}, // R6 unchanged
        '{2'd0, 3'h6, 31'h0,        16'h5555}, // R6 unchanged
        '{2'd0, 3'h1, 31'h0,        16'h0000}, // R2 odd address reads 0
        '{2'd1, 3'h1, 31'hFFFF,     16'h0000}, // R2 odd write ignored
        '{2'd0, 3'h0, 31'h0,        16'h1234}  // R2 inbound untouched
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel = 1'b0; wr = 1'b0; take = 1'b0; post = 1'b0;
    endtask

    // drive at falling edge, let one rising edge pass, release at next falling edge
    task automatic bus_op(input logic w, input logic [2:0] a, input logic [15:0] d,
                          input bit do_chk, input logic [15:0] exp, input string req);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d;
        #2;
        if (do_chk) chk(req, {16'h0, rdata}, {16'h0, exp});
        @(negedge clk);
        idle();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 in_valid", {31'h0, in_valid}, 32'h0);
        chk("R1 out_full", {31'h0, out_full}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 overrun", {31'h0, ovr}, 32'h0);
        for (int a = 0; a < 8; a += 2) bus_op(1'b0, 3'(a), 16'h0, 1'b1, 16'h0, "R1 register reads 0");

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            case (VECS[i].op)
                2'd0: begin sel = 1'b1; wr = 1'b0; addr = VECS[i].addr; end
                2'd1: begin sel = 1'b1; wr = 1'b1; addr = VECS[i].addr; wdata = VECS[i].data[15:0]; end
                2'd2: begin post = 1'b1; pdata = VECS[i].data; end
                default: take = 1'b1;
            endcase
            #2;
            if (VECS[i].op == 2'd0)
                chk($sformatf("vector %0d read", i), {16'h0, rdata}, {16'h0, VECS[i].exp});
            @(negedge clk);
            idle();
        end

        // R3 coprocessor view changes only after the high write
        bus_op(1'b1, 3'h2, 16'h0001, 1'b0, 16'h0, "");
        chk("R3 staged low not visible", {31'h0, in_valid}, 32'h0);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 3'h0; wdata = 16'h8002;
        #2;
        chk("R3 not valid before edge", {31'h0, in_valid}, 32'h0);
        @(negedge clk);
        idle();
        chk("R3 valid after high write", {31'h0, in_valid}, 32'h1);
        chk("R3 published payload", {1'b0, in_data}, 32'h00020001);
        bus_op(1'b1, 3'h2, 16'h7777, 1'b0, 16'h0, "");
        chk("R3 restage keeps payload", {1'b0, in_data}, 32'h00020001);

        // R5 high write and take in the same cycle: write wins
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 3'h0; wdata = 16'h8003; take = 1'b1;
        @(negedge clk);
        idle();
        chk("R5 write beats take valid", {31'h0, in_valid}, 32'h1);
        chk("R5 write beats take data", {1'b0, in_data}, 32'h00037777);

        // R9 interrupt pulse on a fresh post
        @(negedge clk);
        post = 1'b1; pdata = 31'h11112222;
        @(negedge clk);
        idle();
        chk("R9 irq in first full cycle", {31'h0, irq}, 32'h1);
        chk("R7 full after post", {31'h0, out_full}, 32'h1);
        @(negedge clk);
        chk("R9 irq lasts one cycle", {31'h0, irq}, 32'h0);

        // R10 post coincident with low read: replaced, still full, no irq, no overrun
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 3'h6; post = 1'b1; pdata = 31'h33334444;
        #2;
        chk("R10 read returns old low", {16'h0, rdata}, 32'h2222);
        @(negedge clk);
        idle();
        chk("R10 still full", {31'h0, out_full}, 32'h1);
        chk("R10 no irq on refill", {31'h0, irq}, 32'h0);
        chk("R10 no overrun on refill", {31'h0, ovr}, 32'h0);
        bus_op(1'b0, 3'h4, 16'h0, 1'b1, 16'hB333, "R10 replaced high");

        // R10 post while full: overwrite and sticky overrun
        @(negedge clk);
        post = 1'b1; pdata = 31'h55556666;
        @(negedge clk);
        idle();
        chk("R10 overrun set", {31'h0, ovr}, 32'h1);
        chk("R10 no irq while full", {31'h0, irq}, 32'h0);

        // R8 high read keeps the flag, low read clears it
        bus_op(1'b0, 3'h4, 16'h0, 1'b1, 16'hD555, "R8 high read");
        chk("R8 still full after high read", {31'h0, out_full}, 32'h1);
        bus_op(1'b0, 3'h6, 16'h0, 1'b1, 16'h6666, "R8 low read");
        chk("R8 cleared after low read", {31'h0, out_full}, 32'h0);
        @(negedge clk);
        chk("R10 overrun sticky", {31'h0, ovr}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule